// File: doc/BRIEF.md
# Top-Two Priority Encoder

This block takes eight active-low request lines and reports two results: the index of the most urgent asserted line, and the index of the next asserted line below it. Line 7 has the highest priority and line 0 the lowest. Both indices are given as 3-bit active-low codes, so the index value is the bitwise complement of the code. Each index has an active-high valid flag.

The block is built as a chain. A first priority encoder finds the winner. A 3-to-8 decoder turns the winner's index into a one-hot active-low select. An XNOR stage uses that select to raise only the winning line to 1. A second priority encoder then reads the masked lines and gives the runner-up. Adding more decode-and-cancel stages in cascade would yield the third place and beyond.

The `REG_OUT` parameter chooses the output timing. With `REG_OUT = 0`, every path is combinational. With `REG_OUT = 1`, all outputs pass through one register stage that has a synchronous active-low reset.

Top module: `top2_prio_enc`

## Requirements
- R1: `first_idx_n` is the complement of the index p of the highest-numbered line of `req_n` that is 0. For example, p=6 gives code 3'b001.
- R2: `first_valid` is 1 exactly when at least one bit of `req_n` is 0. When it is 0, `first_idx_n` is 3'b111.
- R3: `second_idx_n` is the complement of the index q of the highest line below p that is 0. For example, q=3 gives code 3'b100. Lines below q have no effect on either output.
- R4: `second_valid` is 1 exactly when at least two bits of `req_n` are 0. When it is 0, `second_idx_n` is 3'b111.
- R5: The internal decoder drives exactly one select line low when a line is asserted. It drives none low when no line is asserted.
- R6: The masked lines equal `req_n`, except that the winning line is forced to 1. When no line is asserted, the masked lines equal `req_n` unchanged.
- R7: Whenever `second_valid` is 1, the second index is strictly lower than the first index, and `first_valid` is 1.
- R8: With `REG_OUT = 0`, the outputs follow `req_n` with no clock edge in between.
- R9: With `REG_OUT = 1`, the outputs show the result for the `req_n` value sampled at the previous rising edge of `clk`. While `rst_n` is 0 at a rising edge, both valid flags are cleared and both indices are set to 3'b111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | 8 | Request lines, active low; bit 7 has the highest priority |
| first_idx_n | output | 3 | Active-low index of the top asserted line |
| first_valid | output | 1 | High when any line is asserted |
| second_idx_n | output | 3 | Active-low index of the runner-up line |
| second_valid | output | 1 | High when two or more lines are asserted |

## Verification
The assertions check the following on every clock cycle:
- the decoder select is one-hot or empty, and it agrees with `first_valid`;
- the cancel stage changes exactly one line, or none when nothing is asserted;
- the runner-up always lies below the winner;
- the registered outputs track the combinational result delayed by one edge.

The actual index values, and the claim that lines below q are ignored, can only be shown by the bench. It sweeps all 256 request patterns through both a combinational and a registered instance. It also applies a reset in the middle of the run while requests are active.

// File: rtl/top2_pkg.sv
// Shared constants and types for the top-two priority encoder.
// Assumes exactly eight request lines; the index width follows from that.
package top2_pkg;
    localparam int LINES = 8;
    localparam int IDX_W = $clog2(LINES);
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [LINES-1:0] lines_t;
endpackage

// File: rtl/prio_enc_lo.sv
// Active-low priority encoder. The highest-numbered low input wins.
// Output: the complemented index, plus an active-high "any" flag.
// Assumes: when no input is low, the code is all ones.
module prio_enc_lo #(
    parameter int LINES = top2_pkg::LINES,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] lines_n,
    output logic [IDX_W-1:0] idx_n,
    output logic             any
);
    // Scan upward so that the last (highest) low line found wins.
    always_comb begin
        idx_n = '1;
        any   = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            if (!lines_n[i]) begin
                idx_n = ~IDX_W'(i);
                any   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/idx_dec_lo.sv
// Decodes an active-low index into a one-hot active-low select.
// Assumes: when enable is low, no select line is driven low.
module idx_dec_lo #(
    parameter int LINES = top2_pkg::LINES,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic [IDX_W-1:0] idx_n,
    input  logic             enable,
    output logic [LINES-1:0] sel_n
);
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_sel
            // Drive line g low only when it is the enabled decoded index.
            assign sel_n[g] = !(enable && ((~idx_n) == IDX_W'(g)));
        end
    endgenerate
endmodule

// File: rtl/line_cancel.sv
// Cancels the selected request line with one XNOR per line.
// A low select against a low request gives 1 (the line is cancelled).
// A high select passes the request through unchanged.
// Assumes the select is low only on a line that is itself low.
module line_cancel #(
    parameter int LINES = top2_pkg::LINES
) (
    input  logic [LINES-1:0] req_n,
    input  logic [LINES-1:0] sel_n,
    output logic [LINES-1:0] masked_n
);
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_xnor
            // Per-line XNOR of the request with its select.
            assign masked_n[g] = ~(req_n[g] ^ sel_n[g]);
        end
    endgenerate
endmodule

// File: rtl/top2_prio_enc.sv
// Top-two priority encoder.
// Chain: encode the winner, decode it to a mask, cancel the winner,
// then encode again to get the runner-up.
// REG_OUT=1 adds one output register with a synchronous active-low reset.
// The clock also samples the built-in checks when REG_OUT=0.
module top2_prio_enc #(
    parameter bit REG_OUT = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [top2_pkg::LINES-1:0] req_n,
    output logic [top2_pkg::IDX_W-1:0] first_idx_n,
    output logic                      first_valid,
    output logic [top2_pkg::IDX_W-1:0] second_idx_n,
    output logic                      second_valid
);
    import top2_pkg::*;

    idx_t   win_idx_n, run_idx_n;
    logic   win_any, run_any;
    lines_t sel_n, masked_n;

    prio_enc_lo #(.LINES(LINES)) u_enc_first (
        .lines_n (req_n),
        .idx_n   (win_idx_n),
        .any     (win_any)
    );

    idx_dec_lo #(.LINES(LINES)) u_dec (
        .idx_n  (win_idx_n),
        .enable (win_any),
        .sel_n  (sel_n)
    );

    line_cancel #(.LINES(LINES)) u_cancel (
        .req_n    (req_n),
        .sel_n    (sel_n),
        .masked_n (masked_n)
    );

    prio_enc_lo #(.LINES(LINES)) u_enc_second (
        .lines_n (masked_n),
        .idx_n   (run_idx_n),
        .any     (run_any)
    );

    generate
        if (REG_OUT) begin : g_reg
            // Capture both results each cycle; reset clears valids and idles indices.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    first_idx_n  <= '1;
                    first_valid  <= 1'b0;
                    second_idx_n <= '1;
                    second_valid <= 1'b0;
                end else begin
                    first_idx_n  <= win_idx_n;
                    first_valid  <= win_any;
                    second_idx_n <= run_idx_n;
                    second_valid <= run_any;
                end
            end

            // R9: registered outputs repeat the previous cycle's combinational result.
            assert_reg_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (first_idx_n == $past(win_idx_n)) && (first_valid == $past(win_any))
                    && (second_idx_n == $past(run_idx_n)) && (second_valid == $past(run_any)));
            // R9: the first edge after reset still shows cleared outputs.
            assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(rst_n) |-> !first_valid && !second_valid && (first_idx_n == '1) && (second_idx_n == '1));
        end else begin : g_comb
            // Pass the combinational results straight out.
            assign first_idx_n  = win_idx_n;
            assign first_valid  = win_any;
            assign second_idx_n = run_idx_n;
            assign second_valid = run_any;
        end
    endgenerate

    // R5: the decoder selects at most one line.
    assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n));
    // R5: a line is selected exactly when a winner exists.
    assert_sel_matches_win_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win_any == ($countones(~sel_n) == 1));
    // R6: cancelling changes exactly one line, or none when idle.
    assert_cancel_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(masked_n ^ req_n) == (win_any ? 1 : 0));
    // R6: the changed line goes from asserted to released.
    assert_cancel_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((masked_n ^ req_n) & masked_n) == (masked_n ^ req_n));
    // R7: a runner-up exists only with a winner, and sits below it.
    assert_second_below_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_any |-> win_any && ((~run_idx_n) < (~win_idx_n)));
    // R2: with no winner, the first code is idle.
    assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !win_any |-> (win_idx_n == '1));
    // R4: with no runner-up, the second code is idle.
    assert_idle_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_any |-> (run_idx_n == '1));
endmodule

// File: tb/top2_prio_enc_bench.sv
`timescale 1ns/1ps
// Exhaustive sweep of both output variants against a scan-based model.
module top2_prio_enc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_n = 8'hFF;
    logic [2:0] f_idx, s_idx, rf_idx, rs_idx;
    logic       f_v, s_v, rf_v, rs_v;
    int         checks = 0;
    int         fails  = 0;
    int         cycles = 0;
    bit         done   = 1'b0;

    always #2 clk = ~clk;

    top2_prio_enc #(.REG_OUT(1'b0)) u_top2_prio_enc (
        .clk(clk), .rst_n(rst_n), .req_n(req_n),
        .first_idx_n(f_idx), .first_valid(f_v),
        .second_idx_n(s_idx), .second_valid(s_v)
    );

    top2_prio_enc #(.REG_OUT(1'b1)) u_top2_prio_enc_reg (
        .clk(clk), .rst_n(rst_n), .req_n(req_n),
        .first_idx_n(rf_idx), .first_valid(rf_v),
        .second_idx_n(rs_idx), .second_valid(rs_v)
    );

    // Reference: the two highest zero bits; idle codes are 3'b111.
    task automatic model(input logic [7:0] v, output logic [2:0] ef, output logic ev1,
                         output logic [2:0] es, output logic ev2);
        int found = 0;
        ef = 3'b111; es = 3'b111; ev1 = 1'b0; ev2 = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            if (!v[i]) begin
                if (found == 0) begin ef = ~3'(i); ev1 = 1'b1; end
                else if (found == 1) begin es = ~3'(i); ev2 = 1'b1; end
                found++;
            end
        end
    endtask

    task automatic check(input string tag, input logic [7:0] v,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s req_n=%b actual=%b expected=%b", tag, v, act, exp);
        end
    endtask

    task automatic check_all(input string pfx, input logic [7:0] v,
                             input logic [2:0] fi, input logic fv,
                             input logic [2:0] si, input logic sv);
        logic [2:0] ef, es;
        logic ev1, ev2;
        model(v, ef, ev1, es, ev2);
        check({pfx, " R1 first index"}, v, {5'b0, fi}, {5'b0, ef});
        check({pfx, " R2 first valid"}, v, {7'b0, fv}, {7'b0, ev1});
        // The second index depends on the decode (R5) and cancel (R6) stages.
        check({pfx, " R3 R5 R6 second index"}, v, {5'b0, si}, {5'b0, es});
        check({pfx, " R4 R7 second valid"}, v, {7'b0, sv}, {7'b0, ev2});
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // Reset state: the registered outputs are cleared while rst_n is low (R9).
        req_n = 8'h00;
        repeat (3) @(negedge clk);
        check("R9 reset clears regs", req_n, {rf_idx, rf_v, rs_idx, rs_v}, {3'b111, 1'b0, 3'b111, 1'b0});
        rst_n = 1'b1;
        req_n = 8'hFF;

        // Worked case: lines 6 and 3 are low; lines 2..0 vary and must not matter (R3).
        for (int x = 0; x < 8; x++) begin
            @(negedge clk);
            req_n = {8'b1011_0000} | 8'(x);
            #1;
            check("R3 don't-care first", req_n, {5'b0, f_idx}, 8'b0000_0001);
            check("R3 don't-care second", req_n, {5'b0, s_idx}, 8'b0000_0100);
        end

        // Full sweep, combinational (R8) and then registered one edge later (R9).
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            req_n = 8'(v);
            #1;
            check_all("R8 comb", req_n, f_idx, f_v, s_idx, s_v);
            @(negedge clk);
            check_all("R9 reg", req_n, rf_idx, rf_v, rs_idx, rs_v);
        end

        // Mid-run synchronous reset with active requests (R9).
        @(negedge clk);
        req_n = 8'b0000_0000;
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid-run reset", req_n, {rf_idx, rf_v, rs_idx, rs_v}, {3'b111, 1'b0, 3'b111, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 after reset", req_n, rf_idx, rf_v, rs_idx, rs_v);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule